// File: doc/BRIEF.md
# GPIO Pad Event Detector

This block watches a group of general-purpose input pads and turns selected transitions or levels on them into events. Each pad carries its own detection setting: a 2-bit event mode combined with an input-invert bit. Together they give rising-edge, falling-edge, both-edge, high-level, low-level or no detection. Every qualifying event sets a sticky per-pad interrupt status bit and a sticky per-pad wake status bit. Software clears each of these bits by writing 1 to it.

A per-pad interrupt enable gates the interrupt status into one interrupt line. A per-pad wake enable gates the wake status into one wake line. A pad whose system-control routing input is high never contributes to the wake line. All state is reached through a flat 32-bit register port, which has a single-cycle write strobe and a combinational read. The group holds up to `GRP_PADS` pad positions. Only the lowest `IMPL_PADS` of them are implemented. The rest never report anything.

Top module: `gpev_core`

## Requirements
- R1: After reset, both status registers and both enable registers read 0. Every pad configuration word reads 2 (mode 2, invert 0). `irq_o` and `wake_o` are low.
- R2: Mode 1 with invert 0 sets a pad's status bit on a low-to-high input transition and not on a high-to-low one.
- R3: Mode 1 with invert 1 sets the status bit on a high-to-low transition and not on a low-to-high one.
- R4: Mode 3 sets the status bit on every input transition, in either direction.
- R5: Mode 0 with invert 0 sets the status bit while the input is high. While the level persists, the bit sets again in the same cycle it is cleared.
- R6: Mode 0 with invert 1 sets the status bit while the input is low, and not while it is high.
- R7: Mode 2 never sets the status bit, whatever the input does.
- R8: Writing to word 0 (interrupt status) or word 2 (wake status) clears the bits written as 1. It leaves the bits written as 0 unchanged.
- R9: `irq_o` is high one cycle after any pad has both its interrupt status bit and its enable bit (word 1) set. It is low otherwise.
- R10: The wake status bit sets on every qualifying event, regardless of the interrupt enable. `wake_o` is high one cycle after any pad has its wake status bit and its wake enable bit (word 3) set while its `sci_route_i` bit is low.
- R11: Pad positions at or above `IMPL_PADS` never set status bits. Their configuration words read 0 and ignore writes.
- R12: Register map: word 0 is interrupt status, word 1 is interrupt enable, word 2 is wake status, word 3 is wake enable. Word 8+p is pad p's configuration, with the mode in bits 1:0 and invert in bit 2. Bit p of words 0 to 3 belongs to pad p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pad_i | input | GRP_PADS | Asynchronous pad inputs |
| sci_route_i | input | GRP_PADS | Per-pad system-control routing; high blocks wake |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
Each detection setting gets both input directions on its own pad, so that single-edge modes can be told apart from both-edge and level modes. The bench also checks that falling detection differs from rising detection only through the invert bit. Level modes are checked by clearing the status while the level is held, which shows the difference between a re-arming level and a one-shot edge. The wake path is tried with the interrupt enable off and with the routing input toggled, which separates the wake gating from the interrupt gating. An unimplemented pad is driven with both-edge mode written to its configuration, to show that it stays silent.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

    typedef enum logic [1:0] {
        EV_LEVEL = 2'd0,
        EV_EDGE  = 2'd1,
        EV_OFF   = 2'd2,
        EV_BOTH  = 2'd3
    } ev_mode_e;

    typedef struct packed {
        ev_mode_e mode;
        logic     inv;
    } pad_cfg_t;

    localparam int unsigned W_ISTS    = 0;
    localparam int unsigned W_IEN     = 1;
    localparam int unsigned W_WSTS    = 2;
    localparam int unsigned W_WEN     = 3;
    localparam int unsigned W_CFGBASE = 8;

endpackage

// File: rtl/gpev_sync.sv
module gpev_sync #(
    parameter int unsigned N = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prv_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prv;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d     = q;
        d.s1  = raw_i;
        d.s2  = q.s1;
        d.prv = q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign cur_o = q.s2;
    assign prv_o = q.prv;
endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
    import gpev_pkg::*;
#(
    parameter int unsigned N = 24
) (
    input  pad_cfg_t [N-1:0] cfg_i,
    input  logic     [N-1:0] cur_i,
    input  logic     [N-1:0] prv_i,
    output logic     [N-1:0] hit_o
);
    for (genvar p = 0; p < N; p++) begin : g_pad
        logic now_q, was_q;
        assign now_q = cur_i[p] ^ cfg_i[p].inv;
        assign was_q = prv_i[p] ^ cfg_i[p].inv;
        always_comb begin
            unique case (cfg_i[p].mode)
                EV_LEVEL: hit_o[p] = now_q;
                EV_EDGE:  hit_o[p] = now_q & ~was_q;
                EV_BOTH:  hit_o[p] = now_q ^ was_q;
                default:  hit_o[p] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpev_core.sv
module gpev_core
    import gpev_pkg::*;
#(
    parameter int unsigned GRP_PADS  = 24,
    parameter int unsigned IMPL_PADS = 20,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [GRP_PADS-1:0] pad_i,
    input  logic [GRP_PADS-1:0] sci_route_i,
    input  logic                reg_we_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                irq_o,
    output logic                wake_o
);
    localparam int unsigned CFG_W = $bits(pad_cfg_t);

    function automatic logic [GRP_PADS-1:0] impl_mask();
        logic [GRP_PADS-1:0] m;
        for (int i = 0; i < GRP_PADS; i++) m[i] = (i < IMPL_PADS);
        return m;
    endfunction

    localparam logic [GRP_PADS-1:0] LIVE = impl_mask();

    typedef struct packed {
        logic     [GRP_PADS-1:0] ists;
        logic     [GRP_PADS-1:0] ien;
        logic     [GRP_PADS-1:0] wsts;
        logic     [GRP_PADS-1:0] wen;
        pad_cfg_t [GRP_PADS-1:0] cfg;
        logic                    irq;
        logic                    wake;
    } state_t;

    state_t st_d, st_q;

    logic [GRP_PADS-1:0] cur, prv, hit;
    logic [GRP_PADS-1:0] wr_bits;
    logic                wr_ists, wr_ien, wr_wsts, wr_wen;

    gpev_sync #(.N(GRP_PADS)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (pad_i),
        .cur_o (cur),
        .prv_o (prv)
    );

    gpev_detect #(.N(GRP_PADS)) u_det (
        .cfg_i(st_q.cfg),
        .cur_i(cur),
        .prv_i(prv),
        .hit_o(hit)
    );

    assign wr_bits = reg_wdata_i[GRP_PADS-1:0];
    assign wr_ists = reg_we_i && (reg_addr_i == ADDR_W'(W_ISTS));
    assign wr_ien  = reg_we_i && (reg_addr_i == ADDR_W'(W_IEN));
    assign wr_wsts = reg_we_i && (reg_addr_i == ADDR_W'(W_WSTS));
    assign wr_wen  = reg_we_i && (reg_addr_i == ADDR_W'(W_WEN));

    always_comb begin
        st_d = st_q;
        // sticky status: write-1 clears, a same-cycle event wins
        st_d.ists = ((st_q.ists & ~(wr_ists ? wr_bits : '0)) | hit) & LIVE;
        st_d.wsts = ((st_q.wsts & ~(wr_wsts ? wr_bits : '0)) | hit) & LIVE;
        if (wr_ien) st_d.ien = wr_bits & LIVE;
        if (wr_wen) st_d.wen = wr_bits & LIVE;
        for (int p = 0; p < IMPL_PADS; p++) begin
            if (reg_we_i && reg_addr_i == ADDR_W'(W_CFGBASE + p)) begin
                st_d.cfg[p].mode = ev_mode_e'(reg_wdata_i[1:0]);
                st_d.cfg[p].inv  = reg_wdata_i[2];
            end
        end
        st_d.irq  = |(st_q.ists & st_q.ien);
        st_d.wake = |(st_q.wsts & st_q.wen & ~sci_route_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
            for (int p = 0; p < GRP_PADS; p++) begin
                st_q.cfg[p].mode <= (p < IMPL_PADS) ? EV_OFF : EV_LEVEL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(W_ISTS))      reg_rdata_o[GRP_PADS-1:0] = st_q.ists;
        else if (reg_addr_i == ADDR_W'(W_IEN))  reg_rdata_o[GRP_PADS-1:0] = st_q.ien;
        else if (reg_addr_i == ADDR_W'(W_WSTS)) reg_rdata_o[GRP_PADS-1:0] = st_q.wsts;
        else if (reg_addr_i == ADDR_W'(W_WEN))  reg_rdata_o[GRP_PADS-1:0] = st_q.wen;
        else begin
            for (int p = 0; p < IMPL_PADS; p++) begin
                if (reg_addr_i == ADDR_W'(W_CFGBASE + p)) begin
                    reg_rdata_o[CFG_W-1:0] = {st_q.cfg[p].inv, st_q.cfg[p].mode};
                end
            end
        end
    end

    assign irq_o  = st_q.irq;
    assign wake_o = st_q.wake;

    logic [GRP_PADS-1:0] int_sts, int_en, wk_sts, wk_en;
    assign int_sts = st_q.ists;
    assign int_en  = st_q.ien;
    assign wk_sts  = st_q.wsts;
    assign wk_en   = st_q.wen;
endmodule

// File: rtl/gpev_chk.sv
module gpev_chk #(
    parameter int unsigned GRP_PADS  = 24,
    parameter int unsigned IMPL_PADS = 20,
    parameter int unsigned ADDR_W    = 6
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                reg_we_i,
    input logic [ADDR_W-1:0]   reg_addr_i,
    input logic [31:0]         reg_wdata_i,
    input logic [GRP_PADS-1:0] sci_route_i,
    input logic [GRP_PADS-1:0] int_sts,
    input logic [GRP_PADS-1:0] int_en,
    input logic [GRP_PADS-1:0] wk_sts,
    input logic [GRP_PADS-1:0] wk_en,
    input logic                irq_o,
    input logic                wake_o
);
    logic [GRP_PADS-1:0] dead, clr_i;
    always_comb begin
        for (int i = 0; i < GRP_PADS; i++) dead[i] = (i >= IMPL_PADS);
        clr_i = (reg_we_i && reg_addr_i == '0) ? reg_wdata_i[GRP_PADS-1:0] : '0;
    end

    assert_irq_follows_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (irq_o == $past(|(int_sts & int_en))));

    assert_wake_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (wake_o == $past(|(wk_sts & wk_en & ~sci_route_i))));

    assert_dead_pads_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((int_sts & dead) == '0) && ((wk_sts & dead) == '0));

    assert_zero_write_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (((($past(int_sts) & ~$past(clr_i)) & ~int_sts)) == '0));
endmodule

bind gpev_core gpev_chk #(
    .GRP_PADS (GRP_PADS),
    .IMPL_PADS(IMPL_PADS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .sci_route_i(sci_route_i),
    .int_sts    (int_sts),
    .int_en     (int_en),
    .wk_sts     (wk_sts),
    .wk_en      (wk_en),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
);

// File: tb/tb_gpev_core.sv
module tb_gpev_core;
    localparam int G = 24;
    localparam int IMPL = 20;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [G-1:0]  pad = '0;
    logic [G-1:0]  route = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, wake;
    int            total = 0;
    int            bad = 0;

    always #5 clk = ~clk;

    gpev_core #(.GRP_PADS(G), .IMPL_PADS(IMPL), .ADDR_W(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .sci_route_i(route),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = AW'(a);
        #1;
        d = rdata;
    endtask

    task automatic clear_all();
        wr(0, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a, v); chk("R1 reg zero", v, 0);
        end
        rd(8, v);  chk("R1 R12 cfg pad0 reset", v, 2);
        rd(27, v); chk("R1 cfg pad19 reset", v, 2);
        chk("R1 irq low", irq, 0);
        chk("R1 wake low", wake, 0);
    endtask

    task automatic t_rising();
        logic [31:0] v;
        wr(8, 1); clear_all();
        pad[0] = 1'b1; tick(5);
        rd(0, v); chk("R2 rise sets", v, 32'h1);
        clear_all();
        pad[0] = 1'b0; tick(5);
        rd(0, v); chk("R2 fall ignored", v, 0);
        wr(8, 2);
    endtask

    task automatic t_falling();
        logic [31:0] v;
        wr(9, 5); clear_all();
        pad[1] = 1'b1; tick(5);
        rd(0, v); chk("R3 rise ignored", v, 0);
        pad[1] = 1'b0; tick(5);
        rd(0, v); chk("R3 fall sets", v, 32'h2);
        wr(9, 2); clear_all();
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(10, 3); clear_all();
        pad[2] = 1'b1; tick(5);
        rd(0, v); chk("R4 rise sets", v, 32'h4);
        clear_all();
        pad[2] = 1'b0; tick(5);
        rd(0, v); chk("R4 fall sets", v, 32'h4);
        wr(10, 2); clear_all();
    endtask

    task automatic t_level_high();
        logic [31:0] v;
        wr(11, 0); clear_all(); tick(2);
        rd(0, v); chk("R5 low no set", v, 0);
        pad[3] = 1'b1; tick(5);
        rd(0, v); chk("R5 high sets", v, 32'h8);
        wr(0, 32'h8);
        rd(0, v); chk("R5 R8 held level resets", v, 32'h8);
        pad[3] = 1'b0; tick(5); clear_all();
        rd(0, v); chk("R5 cleared after drop", v, 0);
        wr(11, 2);
    endtask

    task automatic t_level_low();
        logic [31:0] v;
        wr(12, 4); clear_all(); tick(2);
        rd(0, v); chk("R6 low sets", v, 32'h10);
        pad[4] = 1'b1; tick(5); clear_all(); tick(2);
        rd(0, v); chk("R6 high no set", v, 0);
        wr(12, 2);
        rd(12, v); chk("R12 cfg readback", v, 2);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        clear_all();
        pad[5] = 1'b1; tick(5);
        pad[5] = 1'b0; tick(5);
        rd(0, v); chk("R7 off no status", v, 0);
        rd(2, v); chk("R7 off no wake status", v, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(8, 3); wr(10, 3); clear_all();
        pad[0] = 1'b1; pad[2] = 1'b1; tick(5);
        wr(8, 2); wr(10, 2);
        wr(0, 0);
        rd(0, v); chk("R8 zero write keeps", v, 32'h5);
        wr(0, 32'h1);
        rd(0, v); chk("R8 one write clears", v, 32'h4);
        wr(2, 32'h4);
        rd(2, v); chk("R8 wake one clears", v, 32'h1);
        pad[0] = 1'b0; pad[2] = 1'b0; clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(8, 3); clear_all();
        pad[0] = 1'b1; tick(5);
        chk("R9 irq masked", irq, 0);
        wr(1, 32'h1); tick(1);
        rd(1, v); chk("R12 enable readback", v, 32'h1);
        chk("R9 irq raised", irq, 1);
        wr(0, 32'h1); tick(1);
        chk("R9 irq drops on clear", irq, 0);
        wr(1, 0); wr(8, 2); pad[0] = 1'b0; clear_all();
    endtask

    task automatic t_wake();
        logic [31:0] v;
        wr(10, 3); wr(3, 32'h4); clear_all();
        pad[2] = 1'b1; tick(5);
        rd(2, v); chk("R10 wake status set", v, 32'h4);
        chk("R10 wake out", wake, 1);
        chk("R10 irq stays low", irq, 0);
        route[2] = 1'b1; tick(2);
        chk("R10 route blocks wake", wake, 0);
        route[2] = 1'b0; tick(2);
        chk("R10 wake back", wake, 1);
        wr(2, 32'h4); tick(1);
        chk("R10 wake cleared", wake, 0);
        wr(3, 0); wr(10, 2); pad[2] = 1'b0; clear_all();
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(8 + 21, 3); wr(1, 32'hFF_FFFF);
        rd(8 + 21, v); chk("R11 cfg reads 0", v, 0);
        pad[21] = 1'b1; tick(5);
        pad[21] = 1'b0; tick(5);
        rd(0, v); chk("R11 no status", v, 0);
        rd(1, v); chk("R11 enable masked", v, 32'h0F_FFFF);
        chk("R11 no irq", irq, 0);
        wr(1, 0);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_level_high();
        t_level_low();
        t_disabled();
        t_w1c();
        t_irq();
        t_wake();
        t_unimpl();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule